// File: doc/BRIEF.md
# MMU Control Register File

This block holds five 32-bit control registers for a memory management unit: a translation entry high word (virtual page number plus address space identifier), a translation entry low word (physical page number and page flags), a page table base, a fault address, and an MMU control word. A CPU reaches them over a simple register bus at fixed addresses in the top control region. Only privileged accesses are accepted. A user-mode access that hits one of the registers is refused: it changes nothing, a read returns zero, and a violation flag pulses.

Two registers are also written by hardware. When the core reports an MMU or address-error exception, the block stores the faulting virtual address in the fault address register. It also stores that address's upper 22 bits in the page number field of the entry high word. A TLB-load command copies the entry high and entry low words onto a one-cycle TLB write port, which the TLB array consumes.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: Privileged writes store full 32-bit values at 0xFFFFFFF0 (entry high), 0xFFFFFFF4 (entry low), 0xFFFFFFF8 (table base), 0xFFFFFFFC (fault address) and 0xFFFFFFE0 (MMU control). A privileged read of the same address returns the stored value.
- R2: A read accepted in cycle N raises `rd_valid` for exactly one cycle at N+1, with `rd_data`. Back-to-back reads produce back-to-back responses in order. A write is visible to a read issued in the next cycle.
- R3: Entry high holds the ASID in bits 7:0 and the VPN in bits 31:10. Bits 9:8 always read as zero.
- R4: An exception (`exc_valid`) loads `exc_vaddr[31:10]` (22 bits) into the VPN field of entry high and leaves the ASID unchanged. Only software writes change the ASID.
- R5: An exception loads the whole of `exc_vaddr` into the fault address register. The register changes only on an exception or on a software write to it, and holds its value across other accesses.
- R6: When a software write and an exception update the same field in the same cycle, the exception value is stored. Other fields of the written register still take the software value.
- R7: An access with `bus_priv` low to any of the five addresses changes no register. One cycle later it pulses `acc_viol`. A read also returns `rd_valid` with `rd_data` equal to zero.
- R8: Reset clears every bit of the MMU control word except bit 8 (the SV bit), which keeps its value. After reset, `rd_valid`, `acc_viol` and `tlb_we` are low.
- R9: `tlb_load` high in cycle N raises `tlb_we` for one cycle at N+1. At that point `tlb_hi` and `tlb_lo` carry the entry high and entry low values as they were in cycle N, before any write made in that cycle.
- R10: A privileged read of an address in the region that is not one of the five returns zero, with no violation. A write there changes no register.
- R11: Exceptions never change the entry low or the table base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is in privileged mode |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| acc_viol | output | 1 | One-cycle pulse for a refused user-mode access |
| exc_valid | input | 1 | MMU or address-error exception capture strobe |
| exc_vaddr | input | 32 | Faulting virtual address |
| tlb_load | input | 1 | TLB-load command |
| tlb_we | output | 1 | TLB write strobe |
| tlb_hi | output | 32 | Entry high value for the TLB |
| tlb_lo | output | 32 | Entry low value for the TLB |

## Verification
The bench drives exceptions at the same time as software writes to entry high and to the fault address. A design that let the bus win would show the written VPN or fault value instead of the captured address, or would lose the written ASID. It reads entry high after writes with bits 9:8 set and after a capture, so a design that stored bits 9:8 or captured only 20 VPN bits gives a wrong value. The bench resets twice, once with SV set and once with SV clear, which catches a control register that resets SV or fails to clear the other bits. It issues a TLB load together with a write to entry low, which shows whether the port samples the old value. It also makes user-mode and unmapped accesses, which must leave the stored state untouched and must raise or not raise the violation pulse as required.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int NREG      = 5;
  localparam int IDX_HI    = 0;
  localparam int IDX_LO    = 1;
  localparam int IDX_BASE  = 2;
  localparam int IDX_FAULT = 3;
  localparam int IDX_CTL   = 4;

  function automatic logic [31:0] reg_addr(input int idx);
    case (idx)
      IDX_HI:    reg_addr = 32'hFFFF_FFF0;
      IDX_LO:    reg_addr = 32'hFFFF_FFF4;
      IDX_BASE:  reg_addr = 32'hFFFF_FFF8;
      IDX_FAULT: reg_addr = 32'hFFFF_FFFC;
      default:   reg_addr = 32'hFFFF_FFE0;
    endcase
  endfunction

  typedef logic [NREG-1:0][31:0] reg_vals_t;
endpackage

// File: rtl/mmu_rst_sync.sv
module mmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_regs_pkg::*;
(
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic            bus_priv,
  input  logic [31:0]     bus_addr,
  output logic [NREG-1:0] hit_sel,
  output logic [NREG-1:0] wr_sel,
  output logic            rd_fire,
  output logic            rd_ok,
  output logic            viol
);
  logic [NREG-1:0] hit_vec;
  logic            wr_ok;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit_vec[i] = (bus_addr == reg_addr(i));
  end

  always_comb begin
    wr_ok   = bus_req & bus_we & bus_priv;
    rd_fire = bus_req & ~bus_we;
    rd_ok   = rd_fire & bus_priv;
    hit_sel = hit_vec;
    wr_sel  = wr_ok ? hit_vec : '0;
    viol    = bus_req & ~bus_priv & (|hit_vec);
  end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_regs_pkg::*;
#(
  parameter int VPN_LSB = 10,
  parameter int ASID_W  = 8,
  parameter int SV_BIT  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] wr_sel,
  input  logic [31:0]     wdata,
  input  logic            exc_valid,
  input  logic [31:0]     exc_vaddr,
  output reg_vals_t       vals
);
  localparam int VPN_W = 32 - VPN_LSB;
  localparam int GAP_W = VPN_LSB - ASID_W;

  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic              vpn_en;
  logic [ASID_W-1:0] asid_q, asid_d;
  logic              asid_en;
  logic [31:0]       lo_q, base_q, fault_q, fault_d;
  logic              lo_en, base_en, fault_en;
  logic [30:0]       ctl_rst_q, ctl_rst_d;
  logic              sv_q, sv_d;
  logic              ctl_en;
  logic [31:0]       ctl_val;

  // next-state
  always_comb begin
    vpn_en   = wr_sel[IDX_HI] | exc_valid;
    vpn_d    = exc_valid ? exc_vaddr[31:VPN_LSB] : wdata[31:VPN_LSB];
    asid_en  = wr_sel[IDX_HI];
    asid_d   = wdata[ASID_W-1:0];
    lo_en    = wr_sel[IDX_LO];
    base_en  = wr_sel[IDX_BASE];
    fault_en = wr_sel[IDX_FAULT] | exc_valid;
    fault_d  = exc_valid ? exc_vaddr : wdata;
    ctl_en   = wr_sel[IDX_CTL];
    sv_d     = wdata[SV_BIT];
  end

  // control word minus the SV bit, packed into 31 bits
  for (genvar j = 0; j < 31; j++) begin : g_pack
    if (j < SV_BIT) begin : g_lo
      assign ctl_rst_d[j] = wdata[j];
    end else begin : g_hi
      assign ctl_rst_d[j] = wdata[j+1];
    end
  end

  for (genvar b = 0; b < 32; b++) begin : g_unpack
    if (b == SV_BIT) begin : g_sv
      assign ctl_val[b] = sv_q;
    end else if (b < SV_BIT) begin : g_lo
      assign ctl_val[b] = ctl_rst_q[b];
    end else begin : g_hi
      assign ctl_val[b] = ctl_rst_q[b-1];
    end
  end

  // registers without reset
  always_ff @(posedge clk) begin
    if (vpn_en)   vpn_q   <= vpn_d;
    if (asid_en)  asid_q  <= asid_d;
    if (lo_en)    lo_q    <= wdata;
    if (base_en)  base_q  <= wdata;
    if (fault_en) fault_q <= fault_d;
    if (ctl_en)   sv_q    <= sv_d;
  end

  // reset-cleared part of the control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_rst_q <= '0;
    end else if (ctl_en) begin
      ctl_rst_q <= ctl_rst_d;
    end
  end

  always_comb begin
    vals            = '0;
    vals[IDX_HI]    = {vpn_q, {GAP_W{1'b0}}, asid_q};
    vals[IDX_LO]    = lo_q;
    vals[IDX_BASE]  = base_q;
    vals[IDX_FAULT] = fault_q;
    vals[IDX_CTL]   = ctl_val;
  end

  assert_asid_sw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[IDX_HI] |=> $stable(asid_q));
  assert_vpn_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (vpn_q == $past(exc_vaddr[31:VPN_LSB])));
  assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid || wr_sel[IDX_FAULT]) |=> $stable(fault_q));
  assert_exc_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && wr_sel[IDX_FAULT]) |=> (fault_q == $past(exc_vaddr)));
  assert_lo_sw_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[IDX_LO] |=> $stable(lo_q));
  assert_base_sw_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel[IDX_BASE] |=> $stable(base_q));
endmodule

// File: rtl/mmu_bus_resp.sv
module mmu_bus_resp
  import mmu_regs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_fire,
  input  logic            rd_ok,
  input  logic [NREG-1:0] hit_sel,
  input  logic            viol,
  input  reg_vals_t       vals,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  output logic            acc_viol
);
  logic        valid_q, viol_q;
  logic [31:0] data_q, data_d;

  always_comb begin
    data_d = '0;
    if (rd_ok) begin
      for (int i = 0; i < NREG; i++) begin
        if (hit_sel[i]) data_d = data_d | vals[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      valid_q <= rd_fire;
      viol_q  <= viol;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) data_q <= data_d;
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;
  assign acc_viol = viol_q;

  assert_viol_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_viol |=> !acc_viol || $past(viol));
endmodule

// File: rtl/mmu_tlb_port.sv
module mmu_tlb_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tlb_load,
  input  logic [31:0] hi_in,
  input  logic [31:0] lo_in,
  output logic        tlb_we,
  output logic [31:0] tlb_hi,
  output logic [31:0] tlb_lo
);
  logic        we_q;
  logic [31:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= tlb_load;
  end

  always_ff @(posedge clk) begin
    if (tlb_load) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  assign tlb_we = we_q;
  assign tlb_hi = hi_q;
  assign tlb_lo = lo_q;

  assert_tlb_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_load |=> tlb_we);
  assert_tlb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tlb_load |=> !tlb_we);
  assert_tlb_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_load |=> (tlb_hi == $past(hi_in)) && (tlb_lo == $past(lo_in)));
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
#(
  parameter int VPN_LSB = 10,
  parameter int ASID_W  = 8,
  parameter int SV_BIT  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_priv,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        acc_viol,
  input  logic        exc_valid,
  input  logic [31:0] exc_vaddr,
  input  logic        tlb_load,
  output logic        tlb_we,
  output logic [31:0] tlb_hi,
  output logic [31:0] tlb_lo
);
  logic            rst_sync_n;
  logic [NREG-1:0] hit_sel, wr_sel;
  logic            rd_fire, rd_ok, viol;
  reg_vals_t       vals;

  mmu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mmu_addr_decode u_dec (
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_priv (bus_priv),
    .bus_addr (bus_addr),
    .hit_sel  (hit_sel),
    .wr_sel   (wr_sel),
    .rd_fire  (rd_fire),
    .rd_ok    (rd_ok),
    .viol     (viol)
  );

  mmu_reg_bank #(
    .VPN_LSB (VPN_LSB),
    .ASID_W  (ASID_W),
    .SV_BIT  (SV_BIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_sel    (wr_sel),
    .wdata     (bus_wdata),
    .exc_valid (exc_valid),
    .exc_vaddr (exc_vaddr),
    .vals      (vals)
  );

  mmu_bus_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_fire  (rd_fire),
    .rd_ok    (rd_ok),
    .hit_sel  (hit_sel),
    .viol     (viol),
    .vals     (vals),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .acc_viol (acc_viol)
  );

  mmu_tlb_port u_tlb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tlb_load (tlb_load),
    .hi_in    (vals[IDX_HI]),
    .lo_in    (vals[IDX_LO]),
    .tlb_we   (tlb_we),
    .tlb_hi   (tlb_hi),
    .tlb_lo   (tlb_lo)
  );

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_valid |-> $past(bus_req && !bus_we));
  assert_viol_source_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_viol |-> $past(bus_req && !bus_priv));
  assert_viol_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_viol && rd_valid) |-> (rd_data == 32'h0));
endmodule

// File: tb/mmu_ctrl_regs_tb.sv
`timescale 1ns/1ps
module mmu_ctrl_regs_tb;
  localparam logic [31:0] A_HI    = 32'hFFFF_FFF0;
  localparam logic [31:0] A_LO    = 32'hFFFF_FFF4;
  localparam logic [31:0] A_BASE  = 32'hFFFF_FFF8;
  localparam logic [31:0] A_FAULT = 32'hFFFF_FFFC;
  localparam logic [31:0] A_CTL   = 32'hFFFF_FFE0;
  localparam logic [31:0] ALL     = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we, bus_priv;
  logic [31:0] bus_addr, bus_wdata;
  logic        rd_valid, acc_viol;
  logic [31:0] rd_data;
  logic        exc_valid, tlb_load;
  logic [31:0] exc_vaddr;
  logic        tlb_we;
  logic [31:0] tlb_hi, tlb_lo;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        rv;
    logic [31:0] data;
    logic [31:0] mask;
    logic        viol;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mmu_ctrl_regs u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_priv  (bus_priv),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .acc_viol  (acc_viol),
    .exc_valid (exc_valid),
    .exc_vaddr (exc_vaddr),
    .tlb_load  (tlb_load),
    .tlb_we    (tlb_we),
    .tlb_hi    (tlb_hi),
    .tlb_lo    (tlb_lo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each response against the scoreboard queue
  always @(negedge clk) begin
    if (rd_valid || acc_viol) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response actual=rv%0d viol%0d data=%h expected=none",
                 rd_valid, acc_viol, rd_data);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rd_valid !== e.rv || acc_viol !== e.viol ||
            (e.rv && ((rd_data & e.mask) !== (e.data & e.mask)))) begin
          errors++;
          $display("FAIL %s actual=rv%0d viol%0d data=%h expected=rv%0d viol%0d data=%h",
                   e.tag, rd_valid, acc_viol, rd_data & e.mask, e.rv, e.viol, e.data & e.mask);
        end
      end
    end
  end

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                     input logic priv, input logic exc, input logic [31:0] va,
                     input logic tl);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_priv = priv;
    exc_valid = exc; exc_vaddr = va; tlb_load = tl;
    @(negedge clk);
    bus_req = 1'b0; exc_valid = 1'b0; tlb_load = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input logic [31:0] m,
                    input string tag);
    q.push_back('{1'b1, exp, m, 1'b0, tag});
    acc(1'b0, a, 32'h0, 1'b1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 1'b1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; bus_priv = 0;
    exc_valid = 0; exc_vaddr = 0; tlb_load = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: idle outputs and control word after reset
    chk("R8 rd_valid after reset", {31'h0, rd_valid}, 32'h0);
    chk("R8 acc_viol after reset", {31'h0, acc_viol}, 32'h0);
    chk("R8 tlb_we after reset", {31'h0, tlb_we}, 32'h0);
    rd(A_CTL, 32'h0, ~32'h100, "R8 ctl cleared except SV");

    // R1, R3: plain storage and entry high layout
    wr(A_HI, 32'hABCD_E3FF);
    rd(A_HI, 32'hABCD_E0FF, ALL, "R3 entry high bits 9:8 zero");
    wr(A_LO, 32'h0F0F_1234);
    rd(A_LO, 32'h0F0F_1234, ALL, "R1 entry low");
    wr(A_BASE, 32'h8000_1000);
    rd(A_BASE, 32'h8000_1000, ALL, "R1 table base");
    wr(A_FAULT, 32'h55AA_55AA);
    rd(A_FAULT, 32'h55AA_55AA, ALL, "R1 fault address");
    wr(A_CTL, 32'h0000_0113);
    rd(A_CTL, 32'h0000_0113, ALL, "R1 control");

    // R10: unmapped addresses in the region
    rd(32'hFFFF_FFE4, 32'h0, ALL, "R10 unmapped read zero");
    wr(32'hFFFF_FFE8, ALL);
    rd(A_BASE, 32'h8000_1000, ALL, "R10 unmapped write no effect");

    // R7: user-mode accesses
    q.push_back('{1'b0, 32'h0, 32'h0, 1'b1, "R7 user write violation"});
    acc(1'b1, A_LO, 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0, 1'b0);
    q.push_back('{1'b1, 32'h0, ALL, 1'b1, "R7 user read zero"});
    acc(1'b0, A_LO, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0);
    rd(A_LO, 32'h0F0F_1234, ALL, "R7 user write ignored");

    // R2: back-to-back reads
    q.push_back('{1'b1, 32'h0F0F_1234, ALL, 1'b0, "R2 back-to-back first"});
    q.push_back('{1'b1, 32'h8000_1000, ALL, 1'b0, "R2 back-to-back second"});
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_priv = 1; bus_addr = A_LO;
    @(negedge clk);
    bus_addr = A_BASE;
    @(negedge clk);
    bus_req = 0;

    // R4, R5, R11: exception capture
    @(negedge clk);
    exc_valid = 1; exc_vaddr = 32'h1234_5678;
    @(negedge clk);
    exc_valid = 0;
    rd(A_HI, 32'h1234_54FF, ALL, "R4 VPN 22 bits captured, ASID kept");
    rd(A_FAULT, 32'h1234_5678, ALL, "R5 fault address captured");
    rd(A_LO, 32'h0F0F_1234, ALL, "R11 entry low untouched");
    rd(A_BASE, 32'h8000_1000, ALL, "R11 table base untouched");
    wr(A_BASE, 32'h0000_0001);
    wr(A_LO, 32'h0000_0002);
    rd(A_FAULT, 32'h1234_5678, ALL, "R5 fault address held");

    // R6: exception beats a same-cycle write
    acc(1'b1, A_HI, 32'h0000_0C5A, 1'b1, 1'b1, 32'h89AB_CDEF, 1'b0);
    rd(A_HI, 32'h89AB_CC5A, ALL, "R6 VPN from exception, ASID from write");
    acc(1'b1, A_FAULT, 32'h1111_1111, 1'b1, 1'b1, 32'h2222_2222, 1'b0);
    rd(A_FAULT, 32'h2222_2222, ALL, "R6 fault from exception");
    rd(A_HI, 32'h2222_205A, ALL, "R6 entry high after second capture");

    // R9: TLB write port
    wr(A_LO, 32'hCAFE_0077);
    @(negedge clk);
    tlb_load = 1;
    @(negedge clk);
    tlb_load = 0;
    chk("R9 tlb_we pulse", {31'h0, tlb_we}, 32'h1);
    chk("R9 tlb_hi", tlb_hi, 32'h2222_205A);
    chk("R9 tlb_lo", tlb_lo, 32'hCAFE_0077);
    @(negedge clk);
    chk("R9 tlb_we one cycle", {31'h0, tlb_we}, 32'h0);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_priv = 1; bus_addr = A_LO; bus_wdata = 32'h0000_0012;
    tlb_load = 1;
    @(negedge clk);
    bus_req = 0; tlb_load = 0;
    chk("R9 tlb_lo is pre-write value", tlb_lo, 32'hCAFE_0077);
    rd(A_LO, 32'h0000_0012, ALL, "R9 write alongside load stored");

    // R8: SV bit survives reset, other bits clear
    wr(A_CTL, ALL);
    do_reset();
    rd(A_CTL, 32'h0000_0100, ALL, "R8 SV kept set across reset");
    wr(A_CTL, 32'hFFFF_FEFF);
    do_reset();
    rd(A_CTL, 32'h0000_0000, ALL, "R8 SV kept clear across reset");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule